// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block builds the word a flash device drives onto its data bus when the host reads while an internal program or erase is running. A four-state controller tracks whether the device is idle, programming, erasing or in erase suspend. Each read strobe is classified by bank and block. A read that lands in the busy bank returns a status word made of polling, toggle, timeout and erase-window bits. Any other read returns the array data supplied by the core, so the idle bank can be read while the other bank is written.

States: `ST_IDLE`, `ST_PROG`, `ST_ERASE`, `ST_SUSP`. Transitions: START_PROG (`ST_IDLE` to `ST_PROG`, operation active with the program kind), START_ERASE (`ST_IDLE` to `ST_ERASE`, operation active with the erase kind), SUSPEND (`ST_ERASE` to `ST_SUSP`, suspend flag high), RESUME (`ST_SUSP` to `ST_ERASE`, suspend flag low), FINISH (any busy state to `ST_IDLE`, operation flag low). The state register samples the control inputs on each clock edge, so a read is classified by the state from the previous edge. Each read result appears one clock after its strobe. The timers that raise the timeout and window flags sit outside this block.

Top module: `flst_status_gen`

## Requirements
- R1: A read returns `array_data` unchanged when the state is `ST_IDLE` or when `rd_bank` differs from `busy_bank`.
- R2: In `ST_PROG`, a read of the busy bank returns the complement of `prog_d7` in bit 7.
- R3: In `ST_ERASE`, bit 7 of the status word reads 0. In `ST_SUSP`, it reads 1.
- R4: Bit 5 of every status word equals `timeout_hit` in the strobe cycle.
- R5: Bit 3 of the status word equals `erase_window_done` in `ST_ERASE` and `ST_SUSP`, and reads 0 in `ST_PROG`. Bits 0, 1, 4 and 8 and above of every status word read 0.
- R6: Bit 6 reads 0 at the first status read after `ST_IDLE` and inverts after every status read in `ST_PROG` and `ST_ERASE`.
- R7: Bit 2 reads 0 at the first status read after `ST_IDLE`. It inverts after each `ST_ERASE` status read with `rd_blk_hit` high, and holds in `ST_PROG` and on reads with `rd_blk_hit` low.
- R8: In `ST_SUSP`, a busy-bank read with `rd_blk_hit` low returns array data. A read with `rd_blk_hit` high returns status with bit 6 held and bit 2 inverting after each such read.
- R9: `ready` is low in the cycle after `op_active` is sampled high and high in the cycle after it is sampled low.
- R10: `rd_valid` is high for exactly the one cycle after each strobe cycle.
- R11: After reset, `ready` is 1, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_active | input | 1 | Internal program or erase in progress |
| op_kind | input | 1 | 0 = program, 1 = erase |
| busy_bank | input | BANK_W | Bank running the operation |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| timeout_hit | input | 1 | Operation exceeded its time limit |
| erase_window_done | input | 1 | Multi-block erase window expired, erase started |
| erase_susp | input | 1 | Erase suspended |
| rd_stb | input | 1 | Read strobe |
| rd_bank | input | BANK_W | Bank of the read address |
| rd_blk_hit | input | 1 | Read address is in a block selected for (suspended) erase |
| array_data | input | DATA_W | Array data for the read address |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | Read result valid |
| ready | output | 1 | High when no internal operation runs |

## Verification
On every cycle, the assertions check the one-cycle validity pulse, the ready lag and the array passthrough for reads outside the busy bank. They also check that the toggle bits clear in idle, that bit 6 holds in suspend and that bit 2 holds during program. Only the bench scenarios can show the full status word and the toggle sequence across many reads. These scenarios also cover the polling value in each state and the hand-off between suspend and resume, where bit 6 must continue from the value it held when suspend began.

// File: rtl/flst_pkg.sv
package flst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_SUSP  = 2'd3
    } flst_mode_e;

    localparam logic OP_PROGRAM = 1'b0;
    localparam logic OP_ERASE   = 1'b1;

    localparam int BIT_POLL    = 7;
    localparam int BIT_TOGGLE  = 6;
    localparam int BIT_TIMEOUT = 5;
    localparam int BIT_WINDOW  = 3;
    localparam int BIT_ERTOG   = 2;
    localparam int MIN_DATA_W  = 8;
endpackage

// File: rtl/flst_mode_fsm.sv
module flst_mode_fsm
    import flst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_active,
    input  logic       op_kind,
    input  logic       erase_susp,
    output flst_mode_e mode
);
    flst_mode_e mode_nxt;

    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            ST_IDLE: begin
                if (op_active)
                    mode_nxt = (op_kind == OP_ERASE) ? ST_ERASE : ST_PROG;
            end
            ST_PROG: begin
                if (!op_active) mode_nxt = ST_IDLE;
            end
            ST_ERASE: begin
                if (!op_active)     mode_nxt = ST_IDLE;
                else if (erase_susp) mode_nxt = ST_SUSP;
            end
            ST_SUSP: begin
                if (!op_active)      mode_nxt = ST_IDLE;
                else if (!erase_susp) mode_nxt = ST_ERASE;
            end
            default: mode_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= ST_IDLE;
        else        mode <= mode_nxt;
    end

    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_active |=> (mode == ST_IDLE)); // R9
endmodule

// File: rtl/flst_toggle.sv
module flst_toggle
    import flst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  flst_mode_e mode,
    input  logic       stat_rd,
    input  logic       blk_hit,
    output logic       tog_any,
    output logic       tog_blk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_any <= 1'b0;
            tog_blk <= 1'b0;
        end else if (mode == ST_IDLE) begin
            tog_any <= 1'b0;
            tog_blk <= 1'b0;
        end else if (stat_rd) begin
            case (mode)
                ST_PROG: tog_any <= ~tog_any;
                ST_ERASE: begin
                    tog_any <= ~tog_any;
                    if (blk_hit) tog_blk <= ~tog_blk;
                end
                ST_SUSP: tog_blk <= ~tog_blk;
                default: ;
            endcase
        end
    end

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_IDLE) |=> (!tog_any && !tog_blk)); // R6
    AST_SUSP_HOLDS_DQ6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SUSP) |=> $stable(tog_any)); // R8
    AST_PROG_HOLDS_DQ2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_PROG) |=> $stable(tog_blk)); // R7
endmodule

// File: rtl/flst_word.sv
module flst_word
    import flst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  flst_mode_e        mode,
    input  logic              prog_d7,
    input  logic              timeout_hit,
    input  logic              window_done,
    input  logic              tog_any,
    input  logic              tog_blk,
    output logic [DATA_W-1:0] status
);
    logic poll_bit;

    always_comb begin
        unique case (mode)
            ST_PROG:  poll_bit = ~prog_d7;
            ST_ERASE: poll_bit = 1'b0;
            ST_SUSP:  poll_bit = 1'b1;
            default:  poll_bit = 1'b0;
        endcase
    end

    always_comb begin
        status              = '0;
        status[BIT_POLL]    = poll_bit;
        status[BIT_TOGGLE]  = tog_any;
        status[BIT_TIMEOUT] = timeout_hit;
        status[BIT_WINDOW]  = window_done && ((mode == ST_ERASE) || (mode == ST_SUSP));
        status[BIT_ERTOG]   = tog_blk;
    end
endmodule

// File: rtl/flst_status_gen.sv
module flst_status_gen
    import flst_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_active,
    input  logic              op_kind,
    input  logic [BANK_W-1:0] busy_bank,
    input  logic              prog_d7,
    input  logic              timeout_hit,
    input  logic              erase_window_done,
    input  logic              erase_susp,
    input  logic              rd_stb,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic              rd_blk_hit,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ready
);
    localparam int WIDTH_OK = (DATA_W >= MIN_DATA_W) ? 1 : 0;

    flst_mode_e        mode;
    logic              bank_busy;
    logic              stat_rd;
    logic              tog_any;
    logic              tog_blk;
    logic [DATA_W-1:0] status;

    generate
        if (WIDTH_OK == 0) begin : g_bad_width
            initial $error("DATA_W must be at least 8");
        end
    endgenerate

    flst_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_active  (op_active),
        .op_kind    (op_kind),
        .erase_susp (erase_susp),
        .mode       (mode)
    );

    assign bank_busy = (mode != ST_IDLE) && (rd_bank == busy_bank);
    assign stat_rd   = rd_stb && bank_busy && ((mode != ST_SUSP) || rd_blk_hit);

    flst_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .stat_rd (stat_rd),
        .blk_hit (rd_blk_hit),
        .tog_any (tog_any),
        .tog_blk (tog_blk)
    );

    flst_word #(.DATA_W(DATA_W)) u_word (
        .mode        (mode),
        .prog_d7     (prog_d7),
        .timeout_hit (timeout_hit),
        .window_done (erase_window_done),
        .tog_any     (tog_any),
        .tog_blk     (tog_blk),
        .status      (status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            ready    <= 1'b1;
        end else begin
            rd_valid <= rd_stb;
            ready    <= !op_active;
            if (rd_stb) rd_data <= stat_rd ? status : array_data;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid); // R10
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid); // R10
    AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        op_active |=> !ready); // R9
    AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (rd_bank != busy_bank)) |=> (rd_data == $past(array_data))); // R1
endmodule

// File: tb/flst_status_gen_tb_top.sv
`timescale 1ns/1ps
module flst_status_gen_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_active = 1'b0;
    logic          op_kind = 1'b0;
    logic [0:0]    busy_bank = '0;
    logic          prog_d7 = 1'b0;
    logic          timeout_hit = 1'b0;
    logic          erase_window_done = 1'b0;
    logic          erase_susp = 1'b0;
    logic          rd_stb = 1'b0;
    logic [0:0]    rd_bank = '0;
    logic          rd_blk_hit = 1'b0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          ready;

    int n_chk = 0;
    int n_fail = 0;
    int bmode = 0;
    bit e6 = 1'b0;
    bit e2 = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flst_status_gen #(.DATA_W(DW), .BANK_W(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_active(op_active), .op_kind(op_kind),
        .busy_bank(busy_bank), .prog_d7(prog_d7), .timeout_hit(timeout_hit),
        .erase_window_done(erase_window_done), .erase_susp(erase_susp),
        .rd_stb(rd_stb), .rd_bank(rd_bank), .rd_blk_hit(rd_blk_hit),
        .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_word(int m, logic d7, logic to, logic win, bit t6, bit t2);
        logic [DW-1:0] w;
        w = '0;
        w[7] = (m == 1) ? ~d7 : ((m == 3) ? 1'b1 : 1'b0);
        w[6] = t6;
        w[5] = to;
        w[3] = (m >= 2) ? win : 1'b0;
        w[2] = t2;
        return w;
    endfunction

    task automatic set_op(input bit act, input bit kind, input bit susp, input bit bank);
        @(negedge clk);
        op_active = act; op_kind = kind; erase_susp = susp; busy_bank = bank;
        if (!act) begin
            bmode = 0; e6 = 1'b0; e2 = 1'b0;
        end else if (bmode == 0) bmode = kind ? 2 : 1;
        else if (bmode == 2 && susp) bmode = 3;
        else if (bmode == 3 && !susp) bmode = 2;
        @(negedge clk);
        chk("R9 ready", {31'b0, ready}, {31'b0, ~act});
    endtask

    task automatic do_read(input bit bank, input bit hit, input logic [DW-1:0] arr,
                           input bit d7, input bit to, input bit win);
        bit stat;
        logic [DW-1:0] exp;
        string tag;
        @(negedge clk);
        rd_stb = 1'b1; rd_bank = bank; rd_blk_hit = hit; array_data = arr;
        prog_d7 = d7; timeout_hit = to; erase_window_done = win;
        stat = (bmode != 0) && (bank == busy_bank[0]) && ((bmode != 3) || hit);
        if (stat) begin
            exp = exp_word(bmode, d7, to, win, e6, e2);
            case (bmode)
                1: begin tag = "R2 R4 R5 R6 R7 prog status"; e6 = ~e6; end
                2: begin tag = "R3 R4 R5 R6 R7 erase status"; e6 = ~e6; if (hit) e2 = ~e2; end
                default: begin tag = "R3 R5 R8 suspend status"; e2 = ~e2; end
            endcase
        end else begin
            exp = arr;
            tag = (bmode == 3 && bank == busy_bank[0]) ? "R1 R8 suspend array" : "R1 array";
        end
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R10 valid high", {31'b0, rd_valid}, 32'd1);
        chk(tag, {16'b0, rd_data}, {16'b0, exp});
        @(negedge clk);
        chk("R10 valid low", {31'b0, rd_valid}, 32'd0);
    endtask

    task automatic rand_reads(input int n);
        for (int i = 0; i < n; i++)
            do_read(1'($urandom), 1'($urandom), DW'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk("R11 reset ready", {31'b0, ready}, 32'd1);
        chk("R11 reset valid", {31'b0, rd_valid}, 32'd0);
        chk("R11 reset data", {16'b0, rd_data}, 32'd0);
        rst_n = 1'b1;
        rand_reads(6);
        // program in bank 0, first read must show toggles at 0
        set_op(1'b1, 1'b0, 1'b0, 1'b0);
        do_read(1'b0, 1'b1, 16'hA5A5, 1'b1, 1'b0, 1'b1);
        do_read(1'b0, 1'b0, 16'h1234, 1'b0, 1'b1, 1'b0);
        rand_reads(40);
        set_op(1'b0, 1'b0, 1'b0, 1'b0);
        rand_reads(6);
        // erase in bank 1 with suspend and resume
        set_op(1'b1, 1'b1, 1'b0, 1'b1);
        do_read(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        do_read(1'b1, 1'b1, 16'h0F0F, 1'b1, 1'b0, 1'b1);
        rand_reads(40);
        set_op(1'b1, 1'b1, 1'b1, 1'b1);
        do_read(1'b1, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b1);
        do_read(1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b1, 1'b1);
        rand_reads(30);
        set_op(1'b1, 1'b1, 1'b0, 1'b1);
        rand_reads(30);
        set_op(1'b0, 1'b0, 1'b0, 1'b0);
        // program in bank 1, erase in bank 0
        set_op(1'b1, 1'b0, 1'b0, 1'b1);
        rand_reads(30);
        set_op(1'b0, 1'b0, 1'b0, 1'b0);
        set_op(1'b1, 1'b1, 1'b0, 1'b0);
        rand_reads(30);
        set_op(1'b0, 1'b0, 1'b0, 1'b0);
        rand_reads(5);
        done = 1'b1;
        finish_run();
    end
endmodule